// File: doc/BRIEF.md
# System Table Register Unit

This unit holds the four system table registers of a processor core. Two of them, the global table register and the interrupt table register, each hold a 32-bit linear base and a 16-bit byte limit. The software load commands write them directly. The other two, the local table register and the task register, are loaded with a 16-bit selector. For these two, the unit reads the selector's 64-bit descriptor from the global table over a memory read port. It checks the descriptor's type, then fills a hidden cache of base, limit and attributes that the rest of the core reads continuously.

A command is presented with a 3-bit opcode and is taken only while the unit is idle. Bit 2 of the opcode selects store (1) or load (0). Bits 1:0 select the register: 0 global, 1 interrupt, 2 local, 3 task. Each accepted command ends with a one-cycle `done` pulse. `fault` rises with `done` when a selector load is refused. For a store, the read-back value is valid with `done`.

Top module: `systab_regs`

## Requirements
- R1: After reset, the global and interrupt bases are 0 and their limits are 0xFFFF. The local and task selectors are 0, their cached bases are 0 and their cached limits are 0xFFFF. The local valid flag is 0 and `busy` is 0.
- R2: A global or interrupt load writes its base and limit with no memory access. `done` pulses in the cycle after acceptance. A later store of that register returns the base on `rd_base` and the limit on `rd_limit`, with `rd_sel` 0.
- R3: A local or task selector load that passes the selector checks reads the global table at address global base + 8 × index, where the index is selector bits 15:3. `mem_req` and `mem_addr` stay steady until `mem_ack`.
- R4: The descriptor is decoded as follows: base = {bits 63:56, bits 39:16}, limit = bits 15:0, attributes = bits 47:40. The type is attribute bits 3:0 and the system flag is attribute bit 4. A local load whose descriptor has the system flag 0 and type 0x2 fills the local selector, base and limit, and sets local valid.
- R5: A task load whose descriptor has the system flag 0 and type 0x9 or 0xB fills the task selector, base, limit and attributes.
- R6: A store of the local or task register returns only its selector on `rd_sel`, with `rd_base` and `rd_limit` 0. Every load completes with all three read-back outputs 0.
- R7: A selector load faults, with no memory read and no register change, when selector bit 2 is 1 or when 8 × index + 7 exceeds the global limit. An index whose last byte equals the limit is accepted.
- R8: A fetched descriptor whose type or system flag does not fit the target register gives `fault` with `done`, and leaves that register unchanged.
- R9: A local load with index 0 and bit 2 clear needs no memory read and does not fault. It records the selector, clears local valid and completes in the cycle after acceptance.
- R10: The local register may be reloaded at any time. The new descriptor replaces the cached base and limit.
- R11: `busy` is high from the acceptance of a fetching load until the fetch completes. Commands presented while `busy` is high are ignored.
- R12: After a fetch, `done` (and `fault`, if raised) pulses in the cycle after the edge that samples `mem_ack`, and `busy` falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Bit 2 store/load, bits 1:0 register (0 global, 1 interrupt, 2 local, 3 task) |
| cmd_base | input | 32 | Base for global or interrupt loads |
| cmd_limit | input | 16 | Limit for global or interrupt loads |
| cmd_sel | input | 16 | Selector for local or task loads |
| busy | output | 1 | Descriptor fetch in progress; commands ignored |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Load refused (valid with done) |
| rd_base | output | 32 | Store read-back base |
| rd_limit | output | 16 | Store read-back limit |
| rd_sel | output | 16 | Store read-back selector |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ack | input | 1 | Read data valid |
| mem_data | input | 64 | Descriptor read data |
| glob_base | output | 32 | Global table base |
| glob_limit | output | 16 | Global table limit |
| intr_base | output | 32 | Interrupt table base |
| intr_limit | output | 16 | Interrupt table limit |
| local_sel | output | 16 | Local table selector |
| local_base | output | 32 | Cached local table base |
| local_limit | output | 16 | Cached local table limit |
| local_valid | output | 1 | Local table register holds a fetched descriptor |
| task_sel | output | 16 | Task register selector |
| task_base | output | 32 | Cached task segment base |
| task_limit | output | 16 | Cached task segment limit |
| task_attr | output | 8 | Cached task descriptor attributes |

## Verification
Direct loads, stores, refused selectors and null local loads must show `done` exactly one cycle after acceptance. The bench samples `done` at the falling edge that follows the accepting edge. The test memory answers two falling edges after a request. A fetching load's `done` is therefore due on the third falling edge after acceptance: the bench checks `busy` high and `done` low on the second, and `done` high and `busy` low on the third. A scoreboard queue holds one expected completion per accepted command, so a late, missing or surplus `done` is reported.

// File: rtl/systab_pkg.sv
package systab_pkg;
  localparam int ADDR_W = 32;
  localparam int LIM_W  = 16;
  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int ATTR_W = 8;
  localparam int IDX_W  = SEL_W - 3;
  localparam int NUM_TBL = 2;

  typedef enum logic [1:0] {
    REG_GLOB  = 2'd0,
    REG_INTR  = 2'd1,
    REG_LOCAL = 2'd2,
    REG_TASK  = 2'd3
  } reg_id_e;

  typedef struct packed {
    logic    store;
    reg_id_e target;
  } cmd_op_t;

  localparam logic [3:0] TYPE_LTAB   = 4'h2;
  localparam logic [3:0] TYPE_TSS_AV = 4'h9;
  localparam logic [3:0] TYPE_TSS_BS = 4'hB;

  function automatic logic [ADDR_W-1:0] desc_base(input logic [DESC_W-1:0] d);
    return {d[63:56], d[39:32], d[31:16]};
  endfunction

  function automatic logic [LIM_W-1:0] desc_limit(input logic [DESC_W-1:0] d);
    return d[15:0];
  endfunction

  function automatic logic [ATTR_W-1:0] desc_attr(input logic [DESC_W-1:0] d);
    return d[47:40];
  endfunction

  function automatic logic [IDX_W-1:0] sel_index(input logic [SEL_W-1:0] s);
    return s[SEL_W-1:3];
  endfunction

  function automatic logic sel_ti(input logic [SEL_W-1:0] s);
    return s[2];
  endfunction

  // last byte of the 8-byte entry must not pass the table limit
  function automatic logic sel_in_table(input logic [SEL_W-1:0] s,
                                        input logic [LIM_W-1:0] lim);
    logic [LIM_W:0] last_byte;
    last_byte = {1'b0, s[SEL_W-1:3], 3'b111};
    return last_byte <= {1'b0, lim};
  endfunction

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [SEL_W-1:0] s);
    return base + {{(ADDR_W-SEL_W){1'b0}}, s[SEL_W-1:3], 3'b000};
  endfunction

  function automatic logic type_fits(input logic [ATTR_W-1:0] attr, input logic to_task);
    if (attr[4]) return 1'b0;
    if (to_task) return (attr[3:0] == TYPE_TSS_AV) || (attr[3:0] == TYPE_TSS_BS);
    return attr[3:0] == TYPE_LTAB;
  endfunction
endpackage

// File: rtl/systab_table_reg.sv
module systab_table_reg
  import systab_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LIM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_base,
  input  logic [LW-1:0] ld_limit,
  output logic [AW-1:0] base,
  output logic [LW-1:0] limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      limit <= '1;
    end else if (ld) begin
      base  <= ld_base;
      limit <= ld_limit;
    end
  end

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (base == $past(ld_base)) && (limit == $past(ld_limit)));
endmodule

// File: rtl/systab_sel_check.sv
module systab_sel_check
  import systab_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [LIM_W-1:0]  tbl_limit,
  input  logic              to_local,
  output logic              ti_fault,
  output logic              null_sel,
  output logic              range_fault,
  output logic [ADDR_W-1:0] entry
);
  assign ti_fault    = sel_ti(sel);
  assign null_sel    = to_local && !sel_ti(sel) && (sel_index(sel) == '0);
  assign range_fault = !sel_in_table(sel, tbl_limit);
  assign entry       = entry_addr(tbl_base, sel);
endmodule

// File: rtl/systab_fetch.sv
module systab_fetch
  import systab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [SEL_W-1:0]  start_sel,
  input  logic              start_task,
  input  logic              mem_ack,
  input  logic [DESC_W-1:0] mem_data,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fin,
  output logic              fin_ok,
  output logic              fin_task,
  output logic [SEL_W-1:0]  fin_sel,
  output logic [ADDR_W-1:0] fin_base,
  output logic [LIM_W-1:0]  fin_limit,
  output logic [ATTR_W-1:0] fin_attr
);
  typedef enum logic {F_IDLE, F_WAIT} fstate_e;

  fstate_e           state;
  logic [ADDR_W-1:0] addr_q;
  logic [SEL_W-1:0]  sel_q;
  logic              task_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= F_IDLE;
      addr_q <= '0;
      sel_q  <= '0;
      task_q <= 1'b0;
    end else begin
      case (state)
        F_IDLE: if (start) begin
          state  <= F_WAIT;
          addr_q <= start_addr;
          sel_q  <= start_sel;
          task_q <= start_task;
        end
        F_WAIT: if (mem_ack) state <= F_IDLE;
        default: state <= F_IDLE;
      endcase
    end
  end

  assign busy      = (state == F_WAIT);
  assign mem_req   = busy;
  assign mem_addr  = addr_q;
  assign fin       = busy && mem_ack;
  assign fin_task  = task_q;
  assign fin_sel   = sel_q;
  assign fin_attr  = desc_attr(mem_data);
  assign fin_base  = desc_base(mem_data);
  assign fin_limit = desc_limit(mem_data);
  assign fin_ok    = type_fits(fin_attr, task_q);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_start_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_free_after_fin_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
endmodule

// File: rtl/systab_regs.sv
module systab_regs
  import systab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [31:0]       cmd_base,
  input  logic [15:0]       cmd_limit,
  input  logic [15:0]       cmd_sel,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [31:0]       rd_base,
  output logic [15:0]       rd_limit,
  output logic [15:0]       rd_sel,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [63:0]       mem_data,
  output logic [31:0]       glob_base,
  output logic [15:0]       glob_limit,
  output logic [31:0]       intr_base,
  output logic [15:0]       intr_limit,
  output logic [15:0]       local_sel,
  output logic [31:0]       local_base,
  output logic [15:0]       local_limit,
  output logic              local_valid,
  output logic [15:0]       task_sel,
  output logic [31:0]       task_base,
  output logic [15:0]       task_limit,
  output logic [7:0]        task_attr
);
  cmd_op_t op;
  logic    accept, is_load, sel_load, to_task, to_local;
  logic    ti_fault, null_sel, range_fault, sel_fault, local_null, fetch_go, direct_done;
  logic [ADDR_W-1:0] entry;
  logic [ADDR_W-1:0] tbl_base  [NUM_TBL];
  logic [LIM_W-1:0]  tbl_limit [NUM_TBL];

  logic              fin, fin_ok, fin_task;
  logic [SEL_W-1:0]  fin_sel;
  logic [ADDR_W-1:0] fin_base;
  logic [LIM_W-1:0]  fin_limit;
  logic [ATTR_W-1:0] fin_attr;

  assign op          = cmd_op_t'(cmd_op);
  assign accept      = cmd_valid && !busy;
  assign is_load     = accept && !op.store;
  assign to_task     = (op.target == REG_TASK);
  assign to_local    = (op.target == REG_LOCAL);
  assign sel_load    = is_load && (to_task || to_local);
  assign sel_fault   = ti_fault || (!null_sel && range_fault);
  assign local_null  = sel_load && to_local && null_sel;
  assign fetch_go    = sel_load && !sel_fault && !local_null;
  assign direct_done = accept && !fetch_go;

  // global and interrupt table registers share one structure
  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    logic ld_here;
    assign ld_here = is_load && (op.target == reg_id_e'(g));
    systab_table_reg #(.AW(ADDR_W), .LW(LIM_W)) i_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld_here),
      .ld_base  (cmd_base),
      .ld_limit (cmd_limit),
      .base     (tbl_base[g]),
      .limit    (tbl_limit[g])
    );
  end

  assign glob_base  = tbl_base[REG_GLOB];
  assign glob_limit = tbl_limit[REG_GLOB];
  assign intr_base  = tbl_base[REG_INTR];
  assign intr_limit = tbl_limit[REG_INTR];

  systab_sel_check i_chk (
    .sel         (cmd_sel),
    .tbl_base    (glob_base),
    .tbl_limit   (glob_limit),
    .to_local    (to_local),
    .ti_fault    (ti_fault),
    .null_sel    (null_sel),
    .range_fault (range_fault),
    .entry       (entry)
  );

  systab_fetch i_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fetch_go),
    .start_addr (entry),
    .start_sel  (cmd_sel),
    .start_task (to_task),
    .mem_ack    (mem_ack),
    .mem_data   (mem_data),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .fin        (fin),
    .fin_ok     (fin_ok),
    .fin_task   (fin_task),
    .fin_sel    (fin_sel),
    .fin_base   (fin_base),
    .fin_limit  (fin_limit),
    .fin_attr   (fin_attr)
  );

  // hidden caches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_sel   <= '0;
      local_base  <= '0;
      local_limit <= '1;
      local_valid <= 1'b0;
      task_sel    <= '0;
      task_base   <= '0;
      task_limit  <= '1;
      task_attr   <= '0;
    end else begin
      if (local_null) begin
        local_sel   <= cmd_sel;
        local_valid <= 1'b0;
      end else if (fin && fin_ok && !fin_task) begin
        local_sel   <= fin_sel;
        local_base  <= fin_base;
        local_limit <= fin_limit;
        local_valid <= 1'b1;
      end
      if (fin && fin_ok && fin_task) begin
        task_sel   <= fin_sel;
        task_base  <= fin_base;
        task_limit <= fin_limit;
        task_attr  <= fin_attr;
      end
    end
  end

  // completion and read-back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      fault    <= 1'b0;
      rd_base  <= '0;
      rd_limit <= '0;
      rd_sel   <= '0;
    end else begin
      done  <= direct_done || fin;
      fault <= (sel_load && sel_fault) || (fin && !fin_ok);
      if (accept && op.store) begin
        rd_base  <= '0;
        rd_limit <= '0;
        rd_sel   <= '0;
        case (op.target)
          REG_GLOB:  begin rd_base <= glob_base; rd_limit <= glob_limit; end
          REG_INTR:  begin rd_base <= intr_base; rd_limit <= intr_limit; end
          REG_LOCAL: rd_sel <= local_sel;
          default:   rd_sel <= task_sel;
        endcase
      end else if (direct_done || fin) begin
        rd_base  <= '0;
        rd_limit <= '0;
        rd_sel   <= '0;
      end
    end
  end

  assert_fault_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);
  assert_sel_fault_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_load && sel_fault) |=> fault && !mem_req);
  assert_null_local_R9: assert property (@(posedge clk) disable iff (!rst_n)
    local_null |=> !local_valid && !mem_req && !fault && done);
  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(glob_base) && $stable(intr_base) && $stable(local_sel));
  assert_task_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_ok && fin_task) |=> (task_attr[3:0] == TYPE_TSS_AV) || (task_attr[3:0] == TYPE_TSS_BS));
  assert_local_from_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(local_valid) |-> $past(fin));
  assert_done_after_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done);
endmodule

// File: tb/test_systab_regs.sv
module test_systab_regs;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_limit = '0;
  logic [15:0] cmd_sel = '0;
  logic        busy, done, fault, mem_req, local_valid;
  logic [31:0] rd_base, mem_addr, glob_base, intr_base, local_base, task_base;
  logic [15:0] rd_limit, rd_sel, glob_limit, intr_limit, local_sel, local_limit, task_sel, task_limit;
  logic [7:0]  task_attr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_data = '0;

  int checks = 0;
  int fails = 0;
  int reads = 0;
  int lat = 0;
  logic [31:0] exp_addr = '0;

  always #2.5 clk = ~clk;

  systab_regs i_systab_regs (.*);

  typedef struct packed {
    logic        flt;
    logic [31:0] b;
    logic [15:0] l;
    logic [15:0] s;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  logic [63:0] desc_mem [8];

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [15:0] l,
                                          input logic [7:0] a);
    return {b[31:24], 8'h00, a, b[23:0], l};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected done", 64'(done), 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " fault"}, 64'(fault), 64'(e.flt));
        chk({t, " rd_base"}, 64'(rd_base), 64'(e.b));
        chk({t, " rd_limit"}, 64'(rd_limit), 64'(e.l));
        chk({t, " rd_sel"}, 64'(rd_sel), 64'(e.s));
      end
    end
  end

  // memory model: answers two falling edges after the request appears
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == 1) begin
        mem_ack  <= 1'b1;
        mem_data <= desc_mem[mem_addr[5:3]];
        lat      <= 0;
        reads    <= reads + 1;
        chk("R3 fetch address", 64'(mem_addr), 64'(exp_addr));
      end else begin
        lat <= lat + 1;
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [31:0] b, input logic [15:0] l,
                       input logic [15:0] s, input bit fetch, input bit eflt,
                       input logic [31:0] eb, input logic [15:0] el, input logic [15:0] es,
                       input string tag);
    exp_q.push_back('{flt: eflt, b: eb, l: el, s: es});
    tag_q.push_back(tag);
    exp_addr = 32'h1000 + {16'h0, s[15:3], 3'b000};
    cmd_op = op; cmd_base = b; cmd_limit = l; cmd_sel = s; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!fetch) chk({tag, " R2 done one cycle after accept"}, 64'(done), 64'd1);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    desc_mem[0] = '0;
    desc_mem[1] = mk_desc(32'h0000_2000, 16'h00FF, 8'h82);
    desc_mem[2] = mk_desc(32'h1111_1111, 16'h0FFF, 8'h82);
    desc_mem[3] = mk_desc(32'h2233_4455, 16'h0067, 8'h89);
    desc_mem[4] = mk_desc(32'hA5A5_0000, 16'h0100, 8'h8B);
    desc_mem[5] = mk_desc(32'h3000_0000, 16'h1234, 8'h92);
    desc_mem[6] = '0;
    desc_mem[7] = mk_desc(32'h7777_0000, 16'h0777, 8'h82);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 glob_base", 64'(glob_base), 64'h0);
    chk("R1 glob_limit", 64'(glob_limit), 64'hFFFF);
    chk("R1 intr_limit", 64'(intr_limit), 64'hFFFF);
    chk("R1 local_sel", 64'(local_sel), 64'h0);
    chk("R1 local_limit", 64'(local_limit), 64'hFFFF);
    chk("R1 task_sel", 64'(task_sel), 64'h0);
    chk("R1 task_limit", 64'(task_limit), 64'hFFFF);
    chk("R1 local_valid/busy", 64'({local_valid, busy}), 64'h0);

    issue(3'd4, 0, 0, 0, 0, 0, 32'h0, 16'hFFFF, 16'h0, "R1 store glob after reset");
    issue(3'd5, 0, 0, 0, 0, 0, 32'h0, 16'hFFFF, 16'h0, "R1 store intr after reset");
    issue(3'd7, 0, 0, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R6 store task after reset");

    issue(3'd0, 32'h0000_1000, 16'h003F, 0, 0, 0, 0, 0, 0, "R2 load glob");
    chk("R2 glob_base", 64'(glob_base), 64'h1000);
    issue(3'd1, 32'h0800_0000, 16'h07FF, 0, 0, 0, 0, 0, 0, "R2 load intr");
    issue(3'd5, 0, 0, 0, 0, 0, 32'h0800_0000, 16'h07FF, 16'h0, "R2 store intr");
    issue(3'd4, 0, 0, 0, 0, 0, 32'h0000_1000, 16'h003F, 16'h0, "R2 store glob");

    r0 = reads;
    issue(3'd2, 0, 0, 16'h0010, 1, 0, 0, 0, 0, "R4 load local idx2");
    chk("R3 one read", 64'(reads - r0), 64'd1);
    chk("R4 local_base", 64'(local_base), 64'h1111_1111);
    chk("R4 local_limit", 64'(local_limit), 64'h0FFF);
    chk("R4 local_valid", 64'(local_valid), 64'h1);

    issue(3'd2, 0, 0, 16'h0008, 1, 0, 0, 0, 0, "R10 reload local idx1");
    chk("R10 local_base", 64'(local_base), 64'h0000_2000);
    chk("R10 local_limit", 64'(local_limit), 64'h00FF);

    issue(3'd3, 0, 0, 16'h001B, 1, 0, 0, 0, 0, "R5 load task idx3");
    chk("R5 task_base", 64'(task_base), 64'h2233_4455);
    chk("R5 task_limit", 64'(task_limit), 64'h0067);
    chk("R5 task_attr", 64'(task_attr), 64'h89);
    chk("R5 task_sel", 64'(task_sel), 64'h001B);
    issue(3'd7, 0, 0, 0, 0, 0, 32'h0, 16'h0, 16'h001B, "R6 store task");
    issue(3'd6, 0, 0, 0, 0, 0, 32'h0, 16'h0, 16'h0008, "R6 store local");
    issue(3'd3, 0, 0, 16'h0020, 1, 0, 0, 0, 0, "R5 load task busy type");
    chk("R5 task_attr busy type", 64'(task_attr), 64'h8B);

    r0 = reads;
    issue(3'd2, 0, 0, 16'h001C, 0, 1, 0, 0, 0, "R7 table bit set");
    issue(3'd2, 0, 0, 16'h0040, 0, 1, 0, 0, 0, "R7 index past limit");
    chk("R7 no reads", 64'(reads - r0), 64'd0);
    chk("R7 local_sel kept", 64'(local_sel), 64'h0008);
    chk("R7 local_base kept", 64'(local_base), 64'h0000_2000);
    issue(3'd2, 0, 0, 16'h0038, 1, 0, 0, 0, 0, "R7 last index accepted");
    chk("R7 boundary local_base", 64'(local_base), 64'h7777_0000);

    issue(3'd3, 0, 0, 16'h0010, 1, 1, 0, 0, 0, "R8 task gets local type");
    chk("R8 task_base kept", 64'(task_base), 64'hA5A5_0000);
    chk("R8 task_sel kept", 64'(task_sel), 64'h0020);
    issue(3'd2, 0, 0, 16'h0018, 1, 1, 0, 0, 0, "R8 local gets task type");
    issue(3'd2, 0, 0, 16'h0028, 1, 1, 0, 0, 0, "R8 local with system flag set");
    chk("R8 local_sel kept", 64'(local_sel), 64'h0038);
    chk("R8 local_base kept", 64'(local_base), 64'h7777_0000);

    r0 = reads;
    issue(3'd2, 0, 0, 16'h0003, 0, 0, 0, 0, 0, "R9 null local");
    chk("R9 no read", 64'(reads - r0), 64'd0);
    chk("R9 local_valid", 64'(local_valid), 64'h0);
    issue(3'd6, 0, 0, 0, 0, 0, 32'h0, 16'h0, 16'h0003, "R9 store null local");

    // R11/R12: command while busy is ignored; timing of fetch completion
    exp_q.push_back('{flt: 1'b0, b: 32'h0, l: 16'h0, s: 16'h0});
    tag_q.push_back("R11 fetch with ignored command");
    exp_addr = 32'h1010;
    cmd_op = 3'd2; cmd_sel = 16'h0010; cmd_valid = 1'b1;
    @(negedge clk);
    chk("R11 busy after accept", 64'(busy), 64'd1);
    cmd_op = 3'd0; cmd_base = 32'h5555_0000; cmd_limit = 16'h0007;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12 still busy before ack", 64'({busy, done}), 64'b10);
    @(negedge clk);
    chk("R12 done after ack", 64'({busy, done}), 64'b01);
    @(negedge clk);
    chk("R11 glob_base unchanged", 64'(glob_base), 64'h1000);
    issue(3'd4, 0, 0, 0, 0, 0, 32'h0000_1000, 16'h003F, 16'h0, "R11 store glob after ignored load");
    chk("R11 local_base", 64'(local_base), 64'h1111_1111);

    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule